// File: doc/BRIEF.md
# Dual-Port Semaphore Token Unit

This block holds a bank of single-bit lock tokens shared by two independent ports (left and right), so that software on each side can take turns at a shared resource. A port touches the token space when its chip enable is held inactive (high) and its token select is driven active (low). The low address bits pick one token. A write carries a single bit: 0 asks for the token and 1 gives it back. A read returns the token's state replicated across the whole read bus: all zeros to the port that owns it, all ones to every other port.

A request that arrives while the other side holds the token is not dropped. It is remembered, and ownership moves straight to the waiting side when the holder gives the token back. A port's read value can therefore change with no action of its own. Each token runs a five-state machine. The states are FREE, LEFT (left owns, nothing waiting), RIGHT (right owns, nothing waiting), LEFT_RWAIT (left owns, right waiting) and RIGHT_LWAIT (right owns, left waiting). Its transitions are:
- FREE to LEFT on a left request.
- FREE to LEFT_RWAIT on requests from both sides in the same cycle.
- FREE to RIGHT on a right request alone.
- LEFT to FREE on a left release.
- LEFT to RIGHT on a left release paired with a right request.
- LEFT to LEFT_RWAIT on a right request.
- LEFT_RWAIT to RIGHT on a left release.
- LEFT_RWAIT to LEFT on a right release, which cancels the wait.
- LEFT_RWAIT to FREE on releases from both sides.

RIGHT and RIGHT_LWAIT have the mirror-image transitions.

Top module: `sema_unit`

## Requirements
- R1: After reset every token is FREE, and a read from either port returns all ones.
- R2: A port accesses tokens only while its chip enable is 1 and its token select is 0. Writes in any other condition leave every token unchanged, and the port's read bus is all zeros.
- R3: The address chooses exactly one of NUM_SEM tokens. Writes to one token leave all others unchanged.
- R4: A write (write enable low) with data bit 0 requests the token, and with data bit 1 releases it. A read (write enable high) returns all zeros to the owner and all ones otherwise, combinationally.
- R5: A request to a FREE token grants it to the requester at the next clock edge.
- R6: A request to a token held by the other port leaves ownership unchanged and is remembered.
- R7: When the holder releases while the other port waits, ownership passes directly to the waiting port at that edge.
- R8: When the holder releases with nothing waiting, the token becomes FREE and both ports read all ones.
- R9: A release by a port that is waiting cancels its pending request, and the holder keeps the token.
- R10: Requests from both ports to the same FREE token in one cycle grant it to the left port, and the right request stays pending.
- R11: No token is ever owned by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_ce_n | input | 1 | Left chip enable, active low; must be 1 to reach tokens |
| l_sel_n | input | 1 | Left token select, active low |
| l_we_n | input | 1 | Left write enable, active low |
| l_addr | input | ADDR_W (3) | Left token index |
| l_wbit | input | 1 | Left write data: 0 request, 1 release |
| l_rdata | output | DATA_W (16) | Left read data |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_sel_n | input | 1 | Right token select, active low |
| r_we_n | input | 1 | Right write enable, active low |
| r_addr | input | ADDR_W (3) | Right token index |
| r_wbit | input | 1 | Right write data |
| r_rdata | output | DATA_W (16) | Right read data |

## Verification
The bench builds the block with its defaults: eight tokens and a 16-bit read bus. This lets it drive the lowest and highest addresses (0 and 7) and check that the bank uses the full three-bit index. The full-width read bus shows that the status bit is copied onto every line. Each scenario walks one token through a named transition, including the same-cycle tie and the cancel of a pending wait, and reads both ports after each step.

// File: rtl/sema_pkg.sv
package sema_pkg;
    typedef enum logic [2:0] {
        SEM_FREE        = 3'd0,
        SEM_LEFT        = 3'd1,
        SEM_RIGHT       = 3'd2,
        SEM_LEFT_RWAIT  = 3'd3,
        SEM_RIGHT_LWAIT = 3'd4
    } sem_state_e;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec #(
    parameter int NUM_SEM = 8,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input  logic              ce_n,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit,
    output logic [NUM_SEM-1:0] req,
    output logic [NUM_SEM-1:0] rel,
    output logic              rd_act
);
    logic acc;
    assign acc    = ce_n && !sel_n;
    assign rd_act = acc && we_n;

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_dec
        logic hit;
        assign hit    = acc && !we_n && (addr == ADDR_W'(i));
        assign req[i] = hit && !wbit;
        assign rel[i] = hit && wbit;
    end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic own_l,
    output logic own_r,
    output logic wait_l,
    output logic wait_r
);
    sem_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEM_FREE: begin
                if (l_req && r_req)  state_d = SEM_LEFT_RWAIT;
                else if (l_req)      state_d = SEM_LEFT;
                else if (r_req)      state_d = SEM_RIGHT;
            end
            SEM_LEFT: begin
                if (l_rel)           state_d = r_req ? SEM_RIGHT : SEM_FREE;
                else if (r_req)      state_d = SEM_LEFT_RWAIT;
            end
            SEM_RIGHT: begin
                if (r_rel)           state_d = l_req ? SEM_LEFT : SEM_FREE;
                else if (l_req)      state_d = SEM_RIGHT_LWAIT;
            end
            SEM_LEFT_RWAIT: begin
                if (l_rel && r_rel)  state_d = SEM_FREE;
                else if (l_rel)      state_d = SEM_RIGHT;
                else if (r_rel)      state_d = SEM_LEFT;
            end
            SEM_RIGHT_LWAIT: begin
                if (l_rel && r_rel)  state_d = SEM_FREE;
                else if (r_rel)      state_d = SEM_LEFT;
                else if (l_rel)      state_d = SEM_RIGHT;
            end
            default:                 state_d = SEM_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEM_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        own_l  = 1'b0;
        own_r  = 1'b0;
        wait_l = 1'b0;
        wait_r = 1'b0;
        unique case (state_q)
            SEM_FREE:        ;
            SEM_LEFT:        own_l = 1'b1;
            SEM_RIGHT:       own_r = 1'b1;
            SEM_LEFT_RWAIT:  begin own_l = 1'b1; wait_r = 1'b1; end
            SEM_RIGHT_LWAIT: begin own_r = 1'b1; wait_l = 1'b1; end
            default:         ;
        endcase
    end
endmodule

// File: rtl/sema_unit.sv
module sema_unit #(
    parameter int NUM_SEM = 8,
    parameter int DATA_W  = 16,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_ce_n,
    input  logic              l_sel_n,
    input  logic              l_we_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wbit,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_ce_n,
    input  logic              r_sel_n,
    input  logic              r_we_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wbit,
    output logic [DATA_W-1:0] r_rdata
);
    logic [NUM_SEM-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_SEM-1:0] own_l, own_r, wait_l, wait_r;
    logic               l_rd, r_rd;

    sema_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_l (
        .ce_n(l_ce_n), .sel_n(l_sel_n), .we_n(l_we_n), .addr(l_addr),
        .wbit(l_wbit), .req(l_req), .rel(l_rel), .rd_act(l_rd)
    );

    sema_port_dec #(.NUM_SEM(NUM_SEM)) u_dec_r (
        .ce_n(r_ce_n), .sel_n(r_sel_n), .we_n(r_we_n), .addr(r_addr),
        .wbit(r_wbit), .req(r_req), .rel(r_rel), .rd_act(r_rd)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sema_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[i]), .l_rel(l_rel[i]),
            .r_req(r_req[i]), .r_rel(r_rel[i]),
            .own_l(own_l[i]), .own_r(own_r[i]),
            .wait_l(wait_l[i]), .wait_r(wait_r[i])
        );
    end

    assign l_rdata = l_rd ? {DATA_W{~own_l[l_addr]}} : '0;
    assign r_rdata = r_rd ? {DATA_W{~own_r[r_addr]}} : '0;
endmodule

// File: rtl/sema_unit_chk.sv
module sema_unit_chk #(
    parameter int NUM_SEM = 8,
    localparam int ADDR_W = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_ce_n,
    input logic               l_sel_n,
    input logic               l_we_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic               l_wbit,
    input logic               r_ce_n,
    input logic               r_sel_n,
    input logic               r_we_n,
    input logic [ADDR_W-1:0]  r_addr,
    input logic               r_wbit,
    input logic [NUM_SEM-1:0] own_l,
    input logic [NUM_SEM-1:0] own_r,
    input logic [NUM_SEM-1:0] wait_l
);
    logic l_acc, r_acc, l_wq, l_wr, r_wq, r_wr, same;
    assign l_acc = l_ce_n && !l_sel_n;
    assign r_acc = r_ce_n && !r_sel_n;
    assign l_wq  = l_acc && !l_we_n && !l_wbit;
    assign l_wr  = l_acc && !l_we_n &&  l_wbit;
    assign r_wq  = r_acc && !r_we_n && !r_wbit;
    assign r_wr  = r_acc && !r_we_n &&  r_wbit;
    assign same  = (l_addr == r_addr);

    p_mutex_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_acc && !r_acc) |=> ($stable(own_l) && $stable(own_r) && $stable(wait_l)));

    p_grant_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wq && !own_l[l_addr] && !own_r[l_addr]) |=> own_l[$past(l_addr)]);

    p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wq && own_r[l_addr] && !(r_acc && same)) |=> own_r[$past(l_addr)]);

    p_handoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && own_r[r_addr] && wait_l[r_addr] && !(l_acc && same))
        |=> own_l[$past(r_addr)]);

    p_release_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_wr && own_r[r_addr] && !wait_l[r_addr] && !(l_acc && same))
        |=> (!own_l[$past(r_addr)] && !own_r[$past(r_addr)]));

    p_tie_left_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (l_wq && r_wq && same && !own_l[l_addr] && !own_r[l_addr])
        |=> (own_l[$past(l_addr)] && !own_r[$past(l_addr)]));
endmodule

bind sema_unit sema_unit_chk #(.NUM_SEM(NUM_SEM)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_ce_n(l_ce_n), .l_sel_n(l_sel_n), .l_we_n(l_we_n), .l_addr(l_addr), .l_wbit(l_wbit),
    .r_ce_n(r_ce_n), .r_sel_n(r_sel_n), .r_we_n(r_we_n), .r_addr(r_addr), .r_wbit(r_wbit),
    .own_l(own_l), .own_r(own_r), .wait_l(wait_l)
);

// File: tb/sema_unit_tb.sv
module sema_unit_tb;
    localparam int NUM_SEM = 8;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = $clog2(NUM_SEM);
    localparam bit LFT = 1'b0;
    localparam bit RGT = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_ce_n, l_sel_n, l_we_n, l_wbit, r_ce_n, r_sel_n, r_we_n, r_wbit;
    logic [ADDR_W-1:0] l_addr, r_addr;
    logic [DATA_W-1:0] l_rdata, r_rdata;
    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sema_unit #(.NUM_SEM(NUM_SEM), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(l_ce_n), .l_sel_n(l_sel_n), .l_we_n(l_we_n), .l_addr(l_addr),
        .l_wbit(l_wbit), .l_rdata(l_rdata),
        .r_ce_n(r_ce_n), .r_sel_n(r_sel_n), .r_we_n(r_we_n), .r_addr(r_addr),
        .r_wbit(r_wbit), .r_rdata(r_rdata)
    );

    task automatic idle();
        l_ce_n = 1; l_sel_n = 1; l_we_n = 1; l_addr = '0; l_wbit = 1;
        r_ce_n = 1; r_sel_n = 1; r_we_n = 1; r_addr = '0; r_wbit = 1;
    endtask

    task automatic cmp(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one write on one side, across exactly one rising edge.
    task automatic wr(input bit side, input int a, input bit v);
        @(negedge clk);
        if (side == LFT) begin
            l_ce_n = 1; l_sel_n = 0; l_we_n = 0; l_addr = ADDR_W'(a); l_wbit = v;
        end else begin
            r_ce_n = 1; r_sel_n = 0; r_we_n = 0; r_addr = ADDR_W'(a); r_wbit = v;
        end
        @(negedge clk);
        idle();
    endtask

    task automatic wr_both(input int a, input bit lv, input bit rv);
        @(negedge clk);
        l_ce_n = 1; l_sel_n = 0; l_we_n = 0; l_addr = ADDR_W'(a); l_wbit = lv;
        r_ce_n = 1; r_sel_n = 0; r_we_n = 0; r_addr = ADDR_W'(a); r_wbit = rv;
        @(negedge clk);
        idle();
    endtask

    // Combinational read, away from the edge.
    task automatic rd(input bit side, input int a, input bit holds, input string tag);
        logic [DATA_W-1:0] exp;
        exp = holds ? '0 : '1;
        if (side == LFT) begin
            l_ce_n = 1; l_sel_n = 0; l_we_n = 1; l_addr = ADDR_W'(a);
            #1 cmp(tag, l_rdata, exp);
        end else begin
            r_ce_n = 1; r_sel_n = 0; r_we_n = 1; r_addr = ADDR_W'(a);
            #1 cmp(tag, r_rdata, exp);
        end
        idle();
    endtask

    task automatic t_reset();
        for (int i = 0; i < NUM_SEM; i++) begin
            rd(LFT, i, 0, "R1 left reset");
            rd(RGT, i, 0, "R1 right reset");
        end
    endtask

    task automatic t_grant_release();
        wr(LFT, 2, 0);
        rd(LFT, 2, 1, "R5 left granted");
        rd(RGT, 2, 0, "R5 right sees taken");
        wr(LFT, 2, 1);
        rd(LFT, 2, 0, "R8 left free");
        rd(RGT, 2, 0, "R8 right free");
    endtask

    task automatic t_address_isolation();
        wr(RGT, 7, 0);
        rd(RGT, 7, 1, "R3 right holds 7");
        rd(RGT, 0, 0, "R3 token 0 untouched");
        rd(LFT, 6, 0, "R3 token 6 untouched");
        wr(LFT, 0, 0);
        rd(LFT, 0, 1, "R4 left holds 0");
        rd(RGT, 7, 1, "R3 token 7 kept");
        wr(LFT, 0, 1);
        wr(RGT, 7, 1);
        rd(RGT, 7, 0, "R4 release 7");
    endtask

    task automatic t_wait_handoff();
        wr(LFT, 3, 0);
        wr(RGT, 3, 0);
        rd(LFT, 3, 1, "R6 left still owns");
        rd(RGT, 3, 0, "R6 right blocked");
        wr(RGT, 3, 0);
        rd(LFT, 3, 1, "R6 repeat request no change");
        wr(LFT, 3, 1);
        rd(RGT, 3, 1, "R7 right got token");
        rd(LFT, 3, 0, "R7 left released");
        wr(RGT, 3, 1);
        rd(LFT, 3, 0, "R8 free after handoff");
        rd(RGT, 3, 0, "R8 free after handoff");
    endtask

    task automatic t_cancel();
        wr(RGT, 4, 0);
        wr(LFT, 4, 0);
        wr(LFT, 4, 1);
        rd(RGT, 4, 1, "R9 right keeps after cancel");
        wr(RGT, 4, 1);
        rd(LFT, 4, 0, "R9 no grant after cancel");
        rd(RGT, 4, 0, "R9 token free");
    endtask

    task automatic t_tie();
        wr_both(5, 0, 0);
        rd(LFT, 5, 1, "R10 left wins tie");
        rd(RGT, 5, 0, "R11 right not co-owner");
        wr(LFT, 5, 1);
        rd(RGT, 5, 1, "R10 right pending granted");
        wr(RGT, 5, 1);
        rd(LFT, 5, 0, "R10 free at end");
    endtask

    task automatic t_gating();
        // chip enable low: no access
        @(negedge clk);
        l_ce_n = 0; l_sel_n = 0; l_we_n = 0; l_addr = 3'd1; l_wbit = 0;
        #1 cmp("R2 rdata zero when ce low", l_rdata, '0);
        @(negedge clk); idle();
        rd(LFT, 1, 0, "R2 ce low write ignored");
        rd(RGT, 1, 0, "R2 ce low write ignored");
        // select inactive: no access
        @(negedge clk);
        r_ce_n = 1; r_sel_n = 1; r_we_n = 0; r_addr = 3'd1; r_wbit = 0;
        #1 cmp("R2 rdata zero when unselected", r_rdata, '0);
        @(negedge clk); idle();
        rd(RGT, 1, 0, "R2 unselected write ignored");
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        cmp("R2 reset idle rdata", l_rdata, '0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_grant_release();
        t_address_isolation();
        t_wait_handoff();
        t_cancel();
        t_tie();
        t_gating();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule